// File: doc/BRIEF.md
# Multithreaded Decode Stage Flow Controller

This block steers instruction groups through the decode slot of a superscalar, multithreaded pipeline. Each cycle the front end offers one group of up to `WIDTH` slots, all tagged with a single thread number. Every slot carries a sequence number, a payload and a "killed" mark. The block forwards the group to the rename side, one register stage later. It holds the group back when the back end stalls that thread, and it discards slots when the thread is squashed.

Each thread has a small state machine and its own skid FIFO. When the back end stalls a thread, that thread's arriving slots are parked in the FIFO, and a one-cycle block pulse goes back to the front end. When the stall lifts, the FIFO is drained oldest first at up to `WIDTH` entries per cycle. When it is empty, a one-cycle unblock pulse tells the front end to resume.

A squash for a thread empties that thread's FIFO and drops the thread's incoming slots that are younger than the squash point. It also sends an unblock pulse. A summary flag reports whether any thread still has work in flight.

Top module: `dec_flow_ctrl`

## Requirements
- R1: After reset every thread is Idle, `rn_valid`, `fetch_block` and `fetch_unblock` are zero, and `stage_active` is low. The codes in `thread_state` (bits [3t+2:3t] for thread t) are Idle=0, Running=1, Squashing=2, Blocked=3 and Unblocking=4.
- R2: A thread that is Idle, Running or Squashing, and that has neither stall nor squash, forwards its live slots one cycle later. Each slot keeps its position: slot i is at bits [i*SEQ_W +: SEQ_W] of the sequence bus and [i*DATA_W +: DATA_W] of the data bus. The thread becomes Running if at least one slot was live and Idle otherwise; a Squashing thread becomes Running in either case.
- R3: A slot whose killed bit is set is never forwarded and never buffered. The remaining slots that get buffered are packed toward slot 0.
- R4: A stall for a thread moves it to Blocked and parks its incoming live slots in its skid FIFO. It produces no output for that thread. `fetch_block` for the thread pulses for one cycle, only on entry into Blocked.
- R5: A Blocked or Unblocking thread without stall drains its FIFO oldest first, up to WIDTH entries per cycle. Its slots arriving that cycle are appended behind the entries already queued. It stays Unblocking while entries remain.
- R6: When a draining thread's FIFO becomes empty, the thread becomes Running and `fetch_unblock` pulses for one cycle.
- R7: The output group belongs to one thread per cycle. A group being forwarded from the input wins over draining, and among the draining threads the lowest-numbered one is served.
- R8: A squash for thread t drops t's incoming slots whose sequence number is greater than the squash number (unsigned compare), and forwards the others in place. It empties t's FIFO, moves t to Squashing and pulses `fetch_unblock`. A stall in the same cycle is ignored.
- R9: A Squashing thread without a new squash and without stall becomes Running on the next cycle, and its flushed FIFO produces no output.
- R10: `fetch_block` and `fetch_unblock` are never high together for the same thread.
- R11: `stage_active` is high exactly when some thread is Running or Unblocking, or some skid FIFO holds entries.
- R12: Each skid FIFO holds WIDTH*(1+FETCH_LAT) entries and never exceeds that count. A WIDTH larger than MAX_WIDTH is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | WIDTH | Slot occupied flags of the incoming group |
| fetch_killed | input | WIDTH | Slot already-squashed marks |
| fetch_tid | input | TID_W | Thread owning the incoming group |
| fetch_seq | input | WIDTH*SEQ_W | Per-slot sequence numbers |
| fetch_data | input | WIDTH*DATA_W | Per-slot payloads |
| stall_in | input | THREADS | Per-thread stall from the back end |
| squash_in | input | THREADS | Per-thread squash request |
| squash_seq | input | THREADS*SEQ_W | Per-thread squash sequence number |
| rn_valid | output | WIDTH | Slot flags of the outgoing group |
| rn_tid | output | TID_W | Thread owning the outgoing group |
| rn_seq | output | WIDTH*SEQ_W | Outgoing sequence numbers |
| rn_data | output | WIDTH*DATA_W | Outgoing payloads |
| fetch_block | output | THREADS | One-cycle block pulse per thread |
| fetch_unblock | output | THREADS | One-cycle unblock pulse per thread |
| thread_state | output | THREADS*3 | Per-thread state code |
| stage_active | output | 1 | Work-in-flight summary |

## Verification
Every combination of valid mask and killed mask is applied to both threads. This separates forwarding in place from dropping of killed slots, and separates the Running and Idle outcomes. Stall sequences fill a skid FIFO to its full depth while new slots keep arriving during the drain. They show oldest-first order, the limit of WIDTH entries per cycle, and when the unblock pulse fires.

Both threads are released from a stall together, and separately one thread's release is paired with another thread's fresh group. These patterns show the output priority. Squashes with the squash number equal to a slot's sequence number, and below all of them, separate the keep case from the drop case, and show that a thread's buffered entries are gone afterwards.

// File: rtl/dec_flow_pkg.sv
package dec_flow_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        TS_IDLE    = 3'd0,
        TS_RUN     = 3'd1,
        TS_SQUASH  = 3'd2,
        TS_BLOCK   = 3'd3,
        TS_UNBLOCK = 3'd4
    } thr_state_e;
endpackage

// File: rtl/dec_group_pack.sv
// Packs the kept slots of a group toward slot 0 and counts them.
module dec_group_pack #(
    parameter int WIDTH = 2,
    parameter int ENT_W = 16,
    parameter int GRP_W = 2
) (
    input  logic [WIDTH-1:0]       keep,
    input  logic [WIDTH*ENT_W-1:0] in_ents,
    output logic [WIDTH*ENT_W-1:0] out_ents,
    output logic [GRP_W-1:0]       out_cnt
);
    always_comb begin
        int unsigned k;
        k        = 0;
        out_ents = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (keep[i]) begin
                out_ents[k*ENT_W +: ENT_W] = in_ents[i*ENT_W +: ENT_W];
                k = k + 1;
            end
        end
        out_cnt = GRP_W'(k);
    end
endmodule

// File: rtl/dec_skid_fifo.sv
// Per-thread skid FIFO: multi-entry push and pop per cycle, single-cycle flush.
module dec_skid_fifo #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 4,
    parameter int ENT_W = 16,
    parameter int GRP_W = 2,
    parameter int CNT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [GRP_W-1:0]       push_cnt,
    input  logic [WIDTH*ENT_W-1:0] push_ents,
    input  logic [GRP_W-1:0]       pop_cnt,
    output logic [CNT_W-1:0]       cnt,
    output logic [WIDTH*ENT_W-1:0] head_ents
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t fifo_q, fifo_d;

    always_comb begin
        fifo_d = fifo_q;
        if (flush) begin
            fifo_d.rd  = '0;
            fifo_d.wr  = '0;
            fifo_d.cnt = '0;
        end else begin
            for (int i = 0; i < WIDTH; i++) begin
                if (i < int'(push_cnt)) begin
                    fifo_d.mem[(int'(fifo_q.wr) + i) % DEPTH] = push_ents[i*ENT_W +: ENT_W];
                end
            end
            fifo_d.wr  = PTR_W'((int'(fifo_q.wr) + int'(push_cnt)) % DEPTH);
            fifo_d.rd  = PTR_W'((int'(fifo_q.rd) + int'(pop_cnt)) % DEPTH);
            fifo_d.cnt = CNT_W'(int'(fifo_q.cnt) + int'(push_cnt) - int'(pop_cnt));
        end
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            head_ents[i*ENT_W +: ENT_W] = fifo_q.mem[(int'(fifo_q.rd) + i) % DEPTH];
        end
    end

    assign cnt = fifo_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end
endmodule

// File: rtl/dec_flow_ctrl.sv
module dec_flow_ctrl
    import dec_flow_pkg::*;
#(
    parameter int THREADS   = 2,
    parameter int WIDTH     = 2,
    parameter int MAX_WIDTH = 8,
    parameter int SEQ_W     = 8,
    parameter int DATA_W    = 8,
    parameter int FETCH_LAT = 1,
    parameter int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WIDTH-1:0]          fetch_valid,
    input  logic [WIDTH-1:0]          fetch_killed,
    input  logic [TID_W-1:0]          fetch_tid,
    input  logic [WIDTH*SEQ_W-1:0]    fetch_seq,
    input  logic [WIDTH*DATA_W-1:0]   fetch_data,
    input  logic [THREADS-1:0]        stall_in,
    input  logic [THREADS-1:0]        squash_in,
    input  logic [THREADS*SEQ_W-1:0]  squash_seq,
    output logic [WIDTH-1:0]          rn_valid,
    output logic [TID_W-1:0]          rn_tid,
    output logic [WIDTH*SEQ_W-1:0]    rn_seq,
    output logic [WIDTH*DATA_W-1:0]   rn_data,
    output logic [THREADS-1:0]        fetch_block,
    output logic [THREADS-1:0]        fetch_unblock,
    output logic [THREADS*STATE_W-1:0] thread_state,
    output logic                      stage_active
);
    localparam int DEPTH = WIDTH * (1 + FETCH_LAT);
    localparam int ENT_W = SEQ_W + DATA_W;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int GRP_W = $clog2(WIDTH + 1);

    // R12: configuration guard
    if (WIDTH > MAX_WIDTH) begin : g_bad_width
        $error("dec_flow_ctrl: WIDTH exceeds MAX_WIDTH");
    end

    typedef struct packed {
        logic [THREADS-1:0][STATE_W-1:0] st;
        logic [THREADS-1:0]              blk;
        logic [THREADS-1:0]              unblk;
        logic [WIDTH-1:0]                vld;
        logic [TID_W-1:0]                tid;
        logic [WIDTH*SEQ_W-1:0]          seq;
        logic [WIDTH*DATA_W-1:0]         dat;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [WIDTH-1:0]       slot_live;
    logic [WIDTH-1:0]       keep     [THREADS];
    logic [WIDTH*ENT_W-1:0] in_ents;
    logic [WIDTH*ENT_W-1:0] pack_ents;
    logic [GRP_W-1:0]       pack_cnt;
    logic                   flush_c  [THREADS];
    logic [GRP_W-1:0]       push_c   [THREADS];
    logic [GRP_W-1:0]       pop_c    [THREADS];
    logic [CNT_W-1:0]       skid_cnt [THREADS];
    logic [WIDTH*ENT_W-1:0] skid_head[THREADS];
    logic [THREADS*CNT_W-1:0] skid_cnt_flat;

    assign slot_live = fetch_valid & ~fetch_killed;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            in_ents[i*ENT_W +: ENT_W] = {fetch_seq[i*SEQ_W +: SEQ_W], fetch_data[i*DATA_W +: DATA_W]};
        end
    end

    // Per-thread slot keep masks, including the squash age filter
    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            for (int i = 0; i < WIDTH; i++) begin
                keep[t][i] = slot_live[i] && (fetch_tid == TID_W'(t)) &&
                             (!squash_in[t] ||
                              (fetch_seq[i*SEQ_W +: SEQ_W] <= squash_seq[t*SEQ_W +: SEQ_W]));
            end
        end
    end

    dec_group_pack #(
        .WIDTH (WIDTH),
        .ENT_W (ENT_W),
        .GRP_W (GRP_W)
    ) u_pack (
        .keep     (slot_live),
        .in_ents  (in_ents),
        .out_ents (pack_ents),
        .out_cnt  (pack_cnt)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_skid
        dec_skid_fifo #(
            .WIDTH (WIDTH),
            .DEPTH (DEPTH),
            .ENT_W (ENT_W),
            .GRP_W (GRP_W),
            .CNT_W (CNT_W)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush_c[t]),
            .push_cnt  (push_c[t]),
            .push_ents (pack_ents),
            .pop_cnt   (pop_c[t]),
            .cnt       (skid_cnt[t]),
            .head_ents (skid_head[t])
        );
        assign skid_cnt_flat[t*CNT_W +: CNT_W] = skid_cnt[t];
    end

    // Next-state computation
    always_comb begin
        logic             fwd_now;
        logic [WIDTH-1:0] fwd_mask;
        logic             granted;
        logic [TID_W-1:0] gnt;
        int               gpop;
        int               popn;
        int               remain;
        logic             do_push;
        logic             want [THREADS];

        ctl_d       = ctl_q;
        ctl_d.blk   = '0;
        ctl_d.unblk = '0;
        ctl_d.vld   = '0;
        ctl_d.tid   = '0;
        ctl_d.seq   = '0;
        ctl_d.dat   = '0;
        fwd_now     = 1'b0;
        fwd_mask    = '0;
        granted     = 1'b0;
        gnt         = '0;
        gpop        = 0;

        for (int t = 0; t < THREADS; t++) begin
            flush_c[t] = 1'b0;
            push_c[t]  = '0;
            pop_c[t]   = '0;
            want[t]    = 1'b0;
            do_push    = 1'b0;
            if (squash_in[t]) begin
                flush_c[t]        = 1'b1;
                ctl_d.st[t]       = TS_SQUASH;
                ctl_d.unblk[t]    = 1'b1;
                if (|keep[t]) begin
                    fwd_now  = 1'b1;
                    fwd_mask = keep[t];
                end
            end else begin
                case (ctl_q.st[t])
                    TS_BLOCK, TS_UNBLOCK: begin
                        if (stall_in[t]) begin
                            if (ctl_q.st[t] == TS_UNBLOCK) ctl_d.blk[t] = 1'b1;
                            ctl_d.st[t] = TS_BLOCK;
                        end else begin
                            want[t] = 1'b1;
                        end
                        do_push = 1'b1;
                    end
                    default: begin
                        if (stall_in[t]) begin
                            ctl_d.blk[t] = 1'b1;
                            ctl_d.st[t]  = TS_BLOCK;
                            do_push      = 1'b1;
                        end else if (|keep[t]) begin
                            fwd_now     = 1'b1;
                            fwd_mask    = keep[t];
                            ctl_d.st[t] = TS_RUN;
                        end else if (ctl_q.st[t] == TS_SQUASH) begin
                            ctl_d.st[t] = TS_RUN;
                        end else begin
                            ctl_d.st[t] = TS_IDLE;
                        end
                    end
                endcase
            end
            if (do_push && (fetch_tid == TID_W'(t))) push_c[t] = pack_cnt;
        end

        // Drain grant: only when no input group uses the output; lowest thread wins
        for (int t = 0; t < THREADS; t++) begin
            if (!fwd_now && !granted && want[t] && (skid_cnt[t] != '0)) begin
                granted = 1'b1;
                gnt     = TID_W'(t);
            end
        end

        for (int t = 0; t < THREADS; t++) begin
            if (want[t]) begin
                popn = 0;
                if (granted && (gnt == TID_W'(t))) begin
                    popn = (int'(skid_cnt[t]) < WIDTH) ? int'(skid_cnt[t]) : WIDTH;
                    gpop = popn;
                end
                pop_c[t] = GRP_W'(popn);
                remain   = int'(skid_cnt[t]) - popn + int'(push_c[t]);
                if (remain == 0) begin
                    ctl_d.st[t]    = TS_RUN;
                    ctl_d.unblk[t] = 1'b1;
                end else begin
                    ctl_d.st[t]    = TS_UNBLOCK;
                end
            end
        end

        if (fwd_now) begin
            ctl_d.tid = fetch_tid;
            for (int i = 0; i < WIDTH; i++) begin
                if (fwd_mask[i]) begin
                    ctl_d.vld[i]                    = 1'b1;
                    ctl_d.seq[i*SEQ_W +: SEQ_W]     = fetch_seq[i*SEQ_W +: SEQ_W];
                    ctl_d.dat[i*DATA_W +: DATA_W]   = fetch_data[i*DATA_W +: DATA_W];
                end
            end
        end else if (granted) begin
            ctl_d.tid = gnt;
            for (int i = 0; i < WIDTH; i++) begin
                if (i < gpop) begin
                    ctl_d.vld[i]                  = 1'b1;
                    ctl_d.seq[i*SEQ_W +: SEQ_W]   = skid_head[gnt][i*ENT_W + DATA_W +: SEQ_W];
                    ctl_d.dat[i*DATA_W +: DATA_W] = skid_head[gnt][i*ENT_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        stage_active = 1'b0;
        for (int t = 0; t < THREADS; t++) begin
            if ((ctl_q.st[t] == TS_RUN) || (ctl_q.st[t] == TS_UNBLOCK) || (skid_cnt[t] != '0)) begin
                stage_active = 1'b1;
            end
        end
    end

    assign rn_valid      = ctl_q.vld;
    assign rn_tid        = ctl_q.tid;
    assign rn_seq        = ctl_q.seq;
    assign rn_data       = ctl_q.dat;
    assign fetch_block   = ctl_q.blk;
    assign fetch_unblock = ctl_q.unblk;
    assign thread_state  = ctl_q.st;
endmodule

// File: rtl/dec_flow_chk.sv
module dec_flow_chk
    import dec_flow_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int DEPTH   = 4,
    parameter int CNT_W   = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [THREADS-1:0]           stall_in,
    input logic [THREADS-1:0]           squash_in,
    input logic [THREADS-1:0]           fetch_block,
    input logic [THREADS-1:0]           fetch_unblock,
    input logic [THREADS*STATE_W-1:0]   thread_state,
    input logic [THREADS*CNT_W-1:0]     skid_cnt_flat
);
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic [STATE_W-1:0] st;
        assign st = thread_state[t*STATE_W +: STATE_W];

        p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(fetch_block[t] && fetch_unblock[t]));

        p_block_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_block[t] |-> (st == TS_BLOCK));

        p_block_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_block[t] |=> !fetch_block[t]);

        p_unblock_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_unblock[t] |-> ((st == TS_RUN) || (st == TS_SQUASH)));

        p_squash_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
            squash_in[t] |=> ((st == TS_SQUASH) && fetch_unblock[t]));

        p_squash_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((st == TS_SQUASH) && !squash_in[t] && !stall_in[t]) |=> (st == TS_RUN));

        p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
            int'(skid_cnt_flat[t*CNT_W +: CNT_W]) <= DEPTH);
    end
endmodule

bind dec_flow_ctrl dec_flow_chk #(
    .THREADS (THREADS),
    .DEPTH   (DEPTH),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_in      (stall_in),
    .squash_in     (squash_in),
    .fetch_block   (fetch_block),
    .fetch_unblock (fetch_unblock),
    .thread_state  (thread_state),
    .skid_cnt_flat (skid_cnt_flat)
);

// File: tb/dec_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module dec_flow_ctrl_tb_top;
    localparam int ST_IDLE = 0, ST_RUN = 1, ST_SQ = 2, ST_BLK = 3, ST_UNB = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  fetch_valid, fetch_killed, stall_in, squash_in;
    logic        fetch_tid;
    logic [15:0] fetch_seq, fetch_data, squash_seq;
    logic [1:0]  rn_valid, fetch_block, fetch_unblock;
    logic        rn_tid, stage_active;
    logic [15:0] rn_seq, rn_data;
    logic [5:0]  thread_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dec_flow_ctrl #(
        .THREADS(2), .WIDTH(2), .MAX_WIDTH(8), .SEQ_W(8), .DATA_W(8), .FETCH_LAT(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_killed(fetch_killed), .fetch_tid(fetch_tid),
        .fetch_seq(fetch_seq), .fetch_data(fetch_data),
        .stall_in(stall_in), .squash_in(squash_in), .squash_seq(squash_seq),
        .rn_valid(rn_valid), .rn_tid(rn_tid), .rn_seq(rn_seq), .rn_data(rn_data),
        .fetch_block(fetch_block), .fetch_unblock(fetch_unblock),
        .thread_state(thread_state), .stage_active(stage_active)
    );

    function automatic logic [7:0] dat(input int s);
        return 8'(s * 5 + 3);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Drive one cycle of inputs at the falling edge, then advance to the next falling edge
    task automatic cyc(input int tid, input logic [1:0] v, input int s0, input logic [1:0] k,
                       input logic [1:0] stl, input logic [1:0] sq, input int q0, input int q1);
        fetch_tid    = 1'(tid);
        fetch_valid  = v;
        fetch_killed = k;
        fetch_seq    = {8'(s0 + 1), 8'(s0)};
        fetch_data   = {dat(s0 + 1), dat(s0)};
        stall_in     = stl;
        squash_in    = sq;
        squash_seq   = {8'(q1), 8'(q0)};
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic [1:0] stl);
        cyc(0, 2'b00, 0, 2'b00, stl, 2'b00, 0, 0);
    endtask

    task automatic chk_out(input string rq, input logic [1:0] ev, input int et, input int e0, input int e1);
        bit ok;
        n_chk++;
        ok = (rn_valid == ev);
        if (ev != 2'b00) ok = ok && (rn_tid == 1'(et));
        if (ev[0]) ok = ok && (rn_seq[7:0] == 8'(e0)) && (rn_data[7:0] == dat(e0));
        if (ev[1]) ok = ok && (rn_seq[15:8] == 8'(e1)) && (rn_data[15:8] == dat(e1));
        if (!ok) begin
            n_bad++;
            $display("FAIL %s output: got v=%b tid=%0d seq=%h data=%h, expected v=%b tid=%0d seq0=%0d seq1=%0d",
                     rq, rn_valid, rn_tid, rn_seq, rn_data, ev, et, e0, e1);
        end
    endtask

    task automatic chk_st(input string rq, input int t, input int es);
        n_chk++;
        if (int'(thread_state[t*3 +: 3]) != es) begin
            n_bad++;
            $display("FAIL %s thread %0d state: got %0d expected %0d", rq, t, thread_state[t*3 +: 3], es);
        end
    endtask

    task automatic chk_pulse(input string rq, input logic [1:0] eb, input logic [1:0] eu);
        n_chk++;
        if (fetch_block != eb || fetch_unblock != eu) begin
            n_bad++;
            $display("FAIL %s pulses: got block=%b unblock=%b expected block=%b unblock=%b",
                     rq, fetch_block, fetch_unblock, eb, eu);
        end
    endtask

    task automatic chk_act(input string rq, input logic ea);
        n_chk++;
        if (stage_active != ea) begin
            n_bad++;
            $display("FAIL %s stage_active: got %b expected %b", rq, stage_active, ea);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        fetch_tid = 1'b0; fetch_valid = '0; fetch_killed = '0; fetch_seq = '0; fetch_data = '0;
        stall_in = '0; squash_in = '0; squash_seq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_out("R1", 2'b00, 0, 0, 0);
        chk_st("R1", 0, ST_IDLE);
        chk_st("R1", 1, ST_IDLE);
        chk_pulse("R1", 2'b00, 2'b00);
        chk_act("R1", 1'b0);

        // R2 R3: every valid and killed mask for both threads
        for (int tid = 0; tid < 2; tid++) begin
            for (int v = 0; v < 4; v++) begin
                for (int k = 0; k < 4; k++) begin
                    int base;
                    logic [1:0] live;
                    base = 2 * (tid * 16 + v * 4 + k) + 1;
                    live = 2'(v) & ~2'(k);
                    cyc(tid, 2'(v), base, 2'(k), 2'b00, 2'b00, 0, 0);
                    chk_out("R2 R3", live, tid, base, base + 1);
                    chk_st("R2", tid, (live != 2'b00) ? ST_RUN : ST_IDLE);
                    chk_st("R2", 1 - tid, ST_IDLE);
                    chk_pulse("R2", 2'b00, 2'b00);
                end
            end
        end

        // R4 R5 R6 R11 R12: fill thread 0 skid to full depth, drain with a late arrival
        cyc(0, 2'b11, 10, 2'b00, 2'b01, 2'b00, 0, 0);
        chk_out("R4", 2'b00, 0, 0, 0);
        chk_st("R4", 0, ST_BLK);
        chk_pulse("R4", 2'b01, 2'b00);
        chk_act("R11", 1'b1);
        cyc(0, 2'b11, 12, 2'b00, 2'b01, 2'b00, 0, 0);
        chk_out("R4", 2'b00, 0, 0, 0);
        chk_st("R4", 0, ST_BLK);
        chk_pulse("R4", 2'b00, 2'b00);
        cyc(0, 2'b01, 14, 2'b00, 2'b00, 2'b00, 0, 0);
        chk_out("R5", 2'b11, 0, 10, 11);
        chk_st("R5", 0, ST_UNB);
        chk_pulse("R5", 2'b00, 2'b00);
        idle(2'b00);
        chk_out("R5", 2'b11, 0, 12, 13);
        chk_st("R5", 0, ST_UNB);
        idle(2'b00);
        chk_out("R5", 2'b01, 0, 14, 0);
        chk_st("R6", 0, ST_RUN);
        chk_pulse("R6", 2'b00, 2'b01);
        idle(2'b00);
        chk_st("R2", 0, ST_IDLE);
        chk_act("R11", 1'b0);

        // R7: an incoming group wins over draining
        cyc(0, 2'b11, 40, 2'b00, 2'b01, 2'b00, 0, 0);
        chk_st("R4", 0, ST_BLK);
        cyc(1, 2'b11, 50, 2'b00, 2'b00, 2'b00, 0, 0);
        chk_out("R7", 2'b11, 1, 50, 51);
        chk_st("R7", 0, ST_UNB);
        chk_st("R7", 1, ST_RUN);
        idle(2'b00);
        chk_out("R7", 2'b11, 0, 40, 41);
        chk_st("R6", 0, ST_RUN);
        chk_pulse("R6", 2'b00, 2'b01);
        chk_st("R2", 1, ST_IDLE);
        idle(2'b00);

        // R7: lowest-numbered thread drains first
        cyc(0, 2'b11, 60, 2'b00, 2'b11, 2'b00, 0, 0);
        chk_pulse("R4", 2'b11, 2'b00);
        cyc(1, 2'b11, 70, 2'b00, 2'b11, 2'b00, 0, 0);
        chk_pulse("R4", 2'b00, 2'b00);
        chk_st("R4", 1, ST_BLK);
        idle(2'b00);
        chk_out("R7", 2'b11, 0, 60, 61);
        chk_st("R7", 1, ST_UNB);
        chk_pulse("R6", 2'b00, 2'b01);
        idle(2'b00);
        chk_out("R7", 2'b11, 1, 70, 71);
        chk_st("R6", 1, ST_RUN);
        chk_pulse("R6", 2'b00, 2'b10);
        idle(2'b00);

        // R8 R9: squash a blocked thread; equal sequence kept, greater dropped
        cyc(1, 2'b11, 80, 2'b00, 2'b10, 2'b00, 0, 0);
        chk_st("R4", 1, ST_BLK);
        cyc(1, 2'b11, 90, 2'b00, 2'b10, 2'b10, 0, 90);
        chk_out("R8", 2'b01, 1, 90, 0);
        chk_st("R8", 1, ST_SQ);
        chk_pulse("R8", 2'b00, 2'b10);
        idle(2'b00);
        chk_st("R9", 1, ST_RUN);
        chk_out("R9", 2'b00, 0, 0, 0);
        idle(2'b00);
        chk_out("R9", 2'b00, 0, 0, 0);
        chk_st("R9", 1, ST_IDLE);

        // R8: squash number below both slots drops the whole group
        cyc(0, 2'b11, 100, 2'b00, 2'b00, 2'b01, 99, 0);
        chk_out("R8", 2'b00, 0, 0, 0);
        chk_st("R8", 0, ST_SQ);
        chk_pulse("R8", 2'b00, 2'b01);
        cyc(0, 2'b11, 110, 2'b00, 2'b00, 2'b00, 0, 0);
        chk_out("R9", 2'b11, 0, 110, 111);
        chk_st("R9", 0, ST_RUN);
        idle(2'b00);

        // R3: killed slot is not buffered, survivor packs to slot 0
        cyc(0, 2'b11, 120, 2'b01, 2'b01, 2'b00, 0, 0);
        chk_st("R3", 0, ST_BLK);
        idle(2'b00);
        chk_out("R3", 2'b01, 0, 121, 0);
        chk_pulse("R6", 2'b00, 2'b01);
        idle(2'b00);

        // R6: blocked with an empty skid resumes at once
        idle(2'b01);
        chk_st("R4", 0, ST_BLK);
        chk_pulse("R4", 2'b01, 2'b00);
        chk_act("R11", 1'b0);
        idle(2'b00);
        chk_st("R6", 0, ST_RUN);
        chk_pulse("R6", 2'b00, 2'b01);
        chk_out("R6", 2'b00, 0, 0, 0);
        chk_act("R11", 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule